// File: doc/BRIEF.md
# Single-Cycle 14-Bit Nano Processor Core

This block is a small processor core that runs a fixed program held in an internal instruction store. Each 14-bit instruction completes in one clock: it is fetched at the program counter, decoded, its source registers are read, the result and the new status flags are computed, and the destination register, flag register and program counter all update on the same rising edge.

The core has eight general registers addressed by 3-bit fields. The first of them always reads as zero. The last of them is always visible on an output port. The four status flags (overflow, zero, carry, sign) drive their own output pins. Together these outputs give a continuous view of what the program is doing.

The instruction set covers add, two's-complement negate, bitwise and/or/xor/not, logical shifts, rotates by 0 to 3 places, immediate load and a jump taken when a register is zero. The program store and its depth are parameters, so a larger program can be substituted without touching the logic.

Top module: `nano_core`

## Requirements
- R1: Instructions are 14 bits. Bits [13:10] hold the opcode: 0000 add, 0001 negate, 0010 load immediate, 0011 jump-if-zero, 0100 and, 0101 or, 0110 xor, 0111 not, 1000 shift left, 1001 shift right, 1010 rotate left, 1011 rotate right. For add, and, or and xor, the sources are [9:7] and [6:4] and the destination is [2:0]. For negate and not, the source is [9:7] and the destination is [2:0]. For shifts and rotates, the destination is [9:7], the source is [6:4] and the count is [1:0]. Load immediate writes [3:0] into [9:7]. Jump-if-zero tests register [9:7] and jumps to address [PC_W-1:0].
- R2: Add writes the sum modulo 2^DATA_W. Carry is set to the carry out of the top bit. Overflow is set when both operands have the same sign and the result's sign differs from it.
- R3: Negate writes 0 minus the source. Carry is set when the source is nonzero. Overflow is set when the source is the most negative value.
- R4: And, or, xor and not write the bitwise result and clear carry and overflow.
- R5: Shifts move in zeros. Carry takes the last bit shifted out, or 0 when the count is 0. Overflow is cleared.
- R6: Rotates move the bits around circularly. Carry takes the last bit that wrapped around, or 0 when the count is 0. Overflow is cleared.
- R7: Load immediate writes the zero-extended 4-bit value and leaves all four flags unchanged.
- R8: Jump-if-zero loads the target address when the tested register is zero and otherwise advances the program counter by one. It writes no register and leaves the flags unchanged. The program counter wraps from the last address to 0.
- R9: Register 0 always reads as zero, and any write aimed at it has no effect.
- R10: Every arithmetic, logic, shift or rotate instruction sets zero when its result is 0 and sets sign to the result's top bit. Opcodes 1100 to 1111 change nothing except advancing the program counter.
- R11: A synchronous active-high reset clears the program counter, all registers and all flags.
- R12: The output port always shows register 7, and the flag outputs always show the flag register, both in the cycle after the edge that writes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| r7_out | output | DATA_W | Live contents of register 7 |
| flag_v | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_s | output | 1 | Sign flag |

## Verification
The bench builds the core with DATA_W = 4 and PC_W = 5, and supplies its own 32-instruction program through the PROGRAM parameter. With 4-bit data, the program's counter register steps through all 16 values over 16 passes, and a second register advances by 3 each pass, so it also visits all 16 values. As a result, every operation writing register 7 sees every value of its varied operand, and every shift and rotate count from 0 to 3 is covered. The same sweep takes the loop-closing jump in exactly one pass out of sixteen, so both jump outcomes and the natural wrap of the program counter are checked, along with a reset applied in the middle of the run.

// File: rtl/nano_pkg.sv
package nano_pkg;
  localparam int INSN_W = 14;

  localparam logic [3:0] OP_ADD = 4'd0;
  localparam logic [3:0] OP_NEG = 4'd1;
  localparam logic [3:0] OP_MOV = 4'd2;
  localparam logic [3:0] OP_JRZ = 4'd3;
  localparam logic [3:0] OP_AND = 4'd4;
  localparam logic [3:0] OP_OR  = 4'd5;
  localparam logic [3:0] OP_XOR = 4'd6;
  localparam logic [3:0] OP_NOT = 4'd7;
  localparam logic [3:0] OP_SHL = 4'd8;
  localparam logic [3:0] OP_SHR = 4'd9;
  localparam logic [3:0] OP_ROL = 4'd10;
  localparam logic [3:0] OP_ROR = 4'd11;

  typedef struct packed {
    logic v;
    logic z;
    logic c;
    logic s;
  } flags_t;

  typedef struct packed {
    logic [3:0] op;
    logic [2:0] ra;
    logic [2:0] rb;
    logic [2:0] rd;
    logic       wr_en;
    logic       flag_en;
    logic       is_mov;
    logic       is_jrz;
    logic [1:0] shamt;
    logic [3:0] imm;
    logic [6:0] tgt;
  } ctrl_t;

  function automatic logic [INSN_W-1:0] enc_rrr(logic [3:0] op, logic [2:0] a, logic [2:0] b, logic [2:0] d);
    return {op, a, b, 1'b0, d};
  endfunction

  function automatic logic [INSN_W-1:0] enc_un(logic [3:0] op, logic [2:0] a, logic [2:0] d);
    return {op, a, 3'b000, 1'b0, d};
  endfunction

  function automatic logic [INSN_W-1:0] enc_sh(logic [3:0] op, logic [2:0] d, logic [2:0] s, logic [1:0] n);
    return {op, d, s, 2'b00, n};
  endfunction

  function automatic logic [INSN_W-1:0] enc_mov(logic [2:0] d, logic [3:0] imm);
    return {OP_MOV, d, 3'b000, imm};
  endfunction

  function automatic logic [INSN_W-1:0] enc_jrz(logic [2:0] r, logic [6:0] tgt);
    return {OP_JRZ, r, tgt};
  endfunction

  // Eight-entry demonstration program; entry 0 sits in the low bits.
  function automatic logic [8*INSN_W-1:0] demo_program();
    return {enc_jrz(3'd0, 7'd2),
            enc_un(OP_NEG, 3'd7, 3'd7),
            enc_sh(OP_ROR, 3'd7, 3'd7, 2'd1),
            enc_rrr(OP_XOR, 3'd7, 3'd1, 3'd7),
            enc_sh(OP_SHL, 3'd7, 3'd7, 2'd1),
            enc_rrr(OP_ADD, 3'd1, 3'd2, 3'd7),
            enc_mov(3'd2, 4'd3),
            enc_mov(3'd1, 4'd5)};
  endfunction
endpackage

// File: rtl/nano_decode.sv
module nano_decode
  import nano_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output ctrl_t             ctl
);
  always_comb begin
    ctl         = '0;
    ctl.op      = insn[13:10];
    ctl.ra      = insn[9:7];
    ctl.rb      = insn[6:4];
    ctl.rd      = insn[2:0];
    ctl.shamt   = insn[1:0];
    ctl.imm     = insn[3:0];
    ctl.tgt     = insn[6:0];
    case (insn[13:10])
      OP_ADD, OP_AND, OP_OR, OP_XOR, OP_NEG, OP_NOT: begin
        ctl.wr_en   = 1'b1;
        ctl.flag_en = 1'b1;
      end
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        ctl.ra      = insn[6:4];
        ctl.rd      = insn[9:7];
        ctl.wr_en   = 1'b1;
        ctl.flag_en = 1'b1;
      end
      OP_MOV: begin
        ctl.rd     = insn[9:7];
        ctl.wr_en  = 1'b1;
        ctl.is_mov = 1'b1;
      end
      OP_JRZ: ctl.is_jrz = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/nano_regfile.sv
module nano_regfile #(
  parameter  int W    = 4,
  parameter  int NREG = 8,
  localparam int AW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_a_idx,
  input  logic [AW-1:0] rd_b_idx,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  top_reg
);
  // Index 0 has no storage: it is the constant-zero register.
  logic [W-1:0] store [1:NREG-1];

  for (genvar g = 1; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        store[g] <= '0;
      else if (wr_en && wr_idx == AW'(g))
        store[g] <= wr_data;
    end
  end

  assign rd_a    = (rd_a_idx == '0) ? '0 : store[rd_a_idx];
  assign rd_b    = (rd_b_idx == '0) ? '0 : store[rd_b_idx];
  assign top_reg = store[NREG-1];
endmodule

// File: rtl/nano_alu.sv
module nano_alu
  import nano_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   n,
  output logic [W-1:0] res,
  output flags_t       fl
);
  // Returns {v, z, c, s, result}.
  function automatic logic [W+3:0] alu_eval(logic [3:0] f, logic [W-1:0] x, logic [W-1:0] y, logic [1:0] k);
    logic [W:0]   wide;
    logic [W-1:0] r;
    logic         c;
    logic         v;
    wide = '0;
    r    = '0;
    c    = 1'b0;
    v    = 1'b0;
    case (f)
      OP_ADD: begin
        wide = {1'b0, x} + {1'b0, y};
        r    = wide[W-1:0];
        c    = wide[W];
        v    = (x[W-1] == y[W-1]) && (r[W-1] != x[W-1]);
      end
      OP_NEG: begin
        r = '0 - x;
        c = |x;
        v = (x == {1'b1, {(W-1){1'b0}}});
      end
      OP_AND: r = x & y;
      OP_OR:  r = x | y;
      OP_XOR: r = x ^ y;
      OP_NOT: r = ~x;
      OP_SHL: begin
        wide = {1'b0, x} << k;
        r    = wide[W-1:0];
        c    = wide[W];
      end
      OP_SHR: begin
        wide = {x, 1'b0} >> k;
        r    = wide[W:1];
        c    = wide[0];
      end
      OP_ROL: begin
        r = (x << k) | (x >> (W - int'(k)));
        c = (k != 2'd0) && r[0];
      end
      OP_ROR: begin
        r = (x >> k) | (x << (W - int'(k)));
        c = (k != 2'd0) && r[W-1];
      end
      default: ;
    endcase
    return {v, (r == '0), c, r[W-1], r};
  endfunction

  always_comb begin
    {fl, res} = alu_eval(op, a, b, n);
  end
endmodule

// File: rtl/nano_core.sv
module nano_core
  import nano_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int PC_W   = 3,
  parameter logic [INSN_W*(2**PC_W)-1:0] PROGRAM = demo_program()
) (
  input  logic              clk,
  input  logic              rst,
  output logic [DATA_W-1:0] r7_out,
  output logic              flag_v,
  output logic              flag_z,
  output logic              flag_c,
  output logic              flag_s
);
  localparam int NREG = 8;

  logic [PC_W-1:0]   pc;
  logic [PC_W-1:0]   pc_next;
  logic [PC_W-1:0]   jump_target;
  logic              jump_taken;
  logic [INSN_W-1:0] insn;
  ctrl_t             ctl;
  logic [DATA_W-1:0] op_a;
  logic [DATA_W-1:0] op_b;
  logic [DATA_W-1:0] alu_res;
  logic [DATA_W-1:0] wr_data;
  flags_t            alu_fl;
  flags_t            flags_q;
  logic              unused_tgt_bits;

  assign insn = PROGRAM[pc*INSN_W +: INSN_W];

  nano_decode u_dec (
    .insn (insn),
    .ctl  (ctl)
  );

  nano_regfile #(.W(DATA_W), .NREG(NREG)) u_rf (
    .clk      (clk),
    .rst      (rst),
    .rd_a_idx (ctl.ra),
    .rd_b_idx (ctl.rb),
    .rd_a     (op_a),
    .rd_b     (op_b),
    .wr_en    (ctl.wr_en),
    .wr_idx   (ctl.rd),
    .wr_data  (wr_data),
    .top_reg  (r7_out)
  );

  nano_alu #(.W(DATA_W)) u_alu (
    .op  (ctl.op),
    .a   (op_a),
    .b   (op_b),
    .n   (ctl.shamt),
    .res (alu_res),
    .fl  (alu_fl)
  );

  assign wr_data         = ctl.is_mov ? DATA_W'(ctl.imm) : alu_res;
  assign jump_taken      = ctl.is_jrz && (op_a == '0);
  assign jump_target     = ctl.tgt[PC_W-1:0];
  assign pc_next         = jump_taken ? jump_target : pc + 1'b1;
  assign unused_tgt_bits = ^ctl.tgt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= '0;
      flags_q <= '0;
    end else begin
      pc <= pc_next;
      if (ctl.flag_en)
        flags_q <= alu_fl;
    end
  end

  assign flag_v = flags_q.v;
  assign flag_z = flags_q.z;
  assign flag_c = flags_q.c;
  assign flag_s = flags_q.s;
endmodule

// File: rtl/nano_core_chk.sv
module nano_core_chk
  import nano_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int PC_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [PC_W-1:0]   pc,
  input logic              jump_taken,
  input logic [PC_W-1:0]   jump_target,
  input logic              flag_en,
  input logic [DATA_W-1:0] alu_res,
  input flags_t            flags_q,
  input logic [2:0]        rd_a_idx,
  input logic [DATA_W-1:0] op_a,
  input logic              wr_en,
  input logic [2:0]        wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] r7_out
);
  a_r11_reset_clears: assert property (@(posedge clk)
    rst |=> (pc == '0 && r7_out == '0 && flags_q == '0));

  a_r8_jump_lands: assert property (@(posedge clk) disable iff (rst)
    jump_taken |=> pc == $past(jump_target));

  a_r8_pc_advance: assert property (@(posedge clk) disable iff (rst)
    !jump_taken |=> pc == PC_W'($past(pc) + 1'b1));

  a_r7_flags_hold: assert property (@(posedge clk) disable iff (rst)
    !flag_en |=> $stable(flags_q));

  a_r10_zero_flag: assert property (@(posedge clk) disable iff (rst)
    flag_en |=> flags_q.z == ($past(alu_res) == '0));

  a_r9_r0_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_a_idx == 3'd0) |-> (op_a == '0));

  a_r12_r7_tracks_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == 3'd7) |=> r7_out == $past(wr_data));
endmodule

bind nano_core nano_core_chk #(.DATA_W(DATA_W), .PC_W(PC_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pc          (pc),
  .jump_taken  (jump_taken),
  .jump_target (jump_target),
  .flag_en     (ctl.flag_en),
  .alu_res     (alu_res),
  .flags_q     (flags_q),
  .rd_a_idx    (ctl.ra),
  .op_a        (op_a),
  .wr_en       (ctl.wr_en),
  .wr_idx      (ctl.rd),
  .wr_data     (wr_data),
  .r7_out      (r7_out)
);

// File: tb/test_nano_core.sv
module test_nano_core;
  localparam int W   = 4;
  localparam int PCW = 5;
  localparam int N   = 2**PCW;
  localparam int M   = (1 << W);

  localparam int K_ADD = 0, K_NEG = 1, K_MOV = 2, K_JRZ = 3, K_AND = 4, K_OR = 5;
  localparam int K_XOR = 6, K_NOT = 7, K_SHL = 8, K_SHR = 9, K_ROL = 10, K_ROR = 11;

  // Encoders written from the field layout in R1.
  function automatic logic [13:0] i3(int op, int a, int b, int d);
    return 14'((op << 10) | (a << 7) | (b << 4) | d);
  endfunction
  function automatic logic [13:0] i2(int op, int a, int d);
    return 14'((op << 10) | (a << 7) | d);
  endfunction
  function automatic logic [13:0] ish(int op, int d, int s, int n);
    return 14'((op << 10) | (d << 7) | (s << 4) | n);
  endfunction
  function automatic logic [13:0] imv(int d, int imm);
    return 14'((K_MOV << 10) | (d << 7) | imm);
  endfunction
  function automatic logic [13:0] ijz(int r, int t);
    return 14'((K_JRZ << 10) | (r << 7) | t);
  endfunction

  function automatic logic [14*N-1:0] build();
    logic [14*N-1:0] p;
    p = '0;
    p[ 0*14 +: 14] = imv(3, 1);
    p[ 1*14 +: 14] = i3(K_ADD, 1, 3, 1);
    p[ 2*14 +: 14] = imv(5, 3);
    p[ 3*14 +: 14] = i3(K_ADD, 2, 5, 2);
    p[ 4*14 +: 14] = i3(K_ADD, 1, 2, 7);
    p[ 5*14 +: 14] = i2(K_NEG, 1, 7);
    p[ 6*14 +: 14] = i3(K_AND, 1, 2, 7);
    p[ 7*14 +: 14] = i3(K_OR, 1, 2, 7);
    p[ 8*14 +: 14] = i3(K_XOR, 1, 2, 7);
    p[ 9*14 +: 14] = i2(K_NOT, 1, 7);
    p[10*14 +: 14] = ish(K_SHL, 7, 1, 1);
    p[11*14 +: 14] = ish(K_SHL, 7, 2, 3);
    p[12*14 +: 14] = ish(K_SHR, 7, 1, 2);
    p[13*14 +: 14] = ish(K_SHR, 7, 1, 0);
    p[14*14 +: 14] = ish(K_ROL, 7, 1, 1);
    p[15*14 +: 14] = ish(K_ROL, 7, 2, 3);
    p[16*14 +: 14] = ish(K_ROR, 7, 1, 2);
    p[17*14 +: 14] = ish(K_ROR, 7, 2, 1);
    p[18*14 +: 14] = imv(0, 9);
    p[19*14 +: 14] = i3(K_ADD, 0, 1, 7);
    p[20*14 +: 14] = imv(7, 12);
    p[21*14 +: 14] = i3(K_ADD, 1, 0, 0);
    p[22*14 +: 14] = i3(K_ADD, 0, 0, 7);
    p[23*14 +: 14] = 14'b1100_101_011_1101;
    p[24*14 +: 14] = ijz(6, 26);
    p[25*14 +: 14] = imv(7, 15);
    p[26*14 +: 14] = i3(K_ADD, 1, 0, 7);
    p[27*14 +: 14] = ijz(1, 29);
    p[28*14 +: 14] = imv(7, 5);
    p[29*14 +: 14] = 14'b1111_111_111_1111;
    p[30*14 +: 14] = i3(K_ADD, 2, 1, 7);
    p[31*14 +: 14] = ish(K_SHR, 7, 7, 1);
    return p;
  endfunction

  localparam logic [14*N-1:0] PROG = build();

  logic       clk;
  logic       rst;
  logic [W-1:0] r7_out;
  logic       flag_v, flag_z, flag_c, flag_s;

  nano_core #(.DATA_W(W), .PC_W(PCW), .PROGRAM(PROG)) i_nano_core (
    .clk    (clk),
    .rst    (rst),
    .r7_out (r7_out),
    .flag_v (flag_v),
    .flag_z (flag_z),
    .flag_c (flag_c),
    .flag_s (flag_s)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int    n_checks = 0;
  int    n_err    = 0;
  bit    done     = 0;
  int    m_reg [8];
  int    m_v, m_z, m_c, m_s, m_pc;
  string tag;

  task automatic model_reset();
    for (int i = 0; i < 8; i++) m_reg[i] = 0;
    m_v = 0; m_z = 0; m_c = 0; m_s = 0; m_pc = 0;
  endtask

  function automatic int sgn(int x);
    return (x >= M/2) ? x - M : x;
  endfunction

  task automatic step();
    logic [13:0] insn;
    int op, f1, f2, lo, n, a, b, res, c, v, dst, ss;
    insn = PROG[m_pc*14 +: 14];
    op = int'(insn[13:10]); f1 = int'(insn[9:7]); f2 = int'(insn[6:4]);
    lo = int'(insn[2:0]); n = int'(insn[1:0]);
    c = 0; v = 0; res = 0; dst = lo;
    a = m_reg[f1]; b = m_reg[f2];
    if (op >= K_SHL && op <= K_ROR) begin a = m_reg[f2]; dst = f1; end
    case (op)
      K_ADD: begin
        res = (a + b) % M; c = (a + b) >= M ? 1 : 0;
        ss = sgn(a) + sgn(b); v = (ss >= M/2 || ss < -(M/2)) ? 1 : 0; tag = "R2";
      end
      K_NEG: begin res = (M - a) % M; c = (a != 0); v = (a == M/2); tag = "R3"; end
      K_AND: begin res = a & b; tag = "R4"; end
      K_OR:  begin res = a | b; tag = "R4"; end
      K_XOR: begin res = a ^ b; tag = "R4"; end
      K_NOT: begin res = (M - 1) - a; tag = "R4"; end
      K_SHL: begin res = (a << n) % M; c = (n > 0) ? (a >> (W - n)) & 1 : 0; tag = "R5"; end
      K_SHR: begin res = a >> n; c = (n > 0) ? (a >> (n - 1)) & 1 : 0; tag = "R5"; end
      K_ROL: begin
        res = (n == 0) ? a : ((a << n) | (a >> (W - n))) % M;
        c = (n > 0) ? res & 1 : 0; tag = "R6";
      end
      K_ROR: begin
        res = (n == 0) ? a : ((a >> n) | (a << (W - n))) % M;
        c = (n > 0) ? (res >> (W - 1)) & 1 : 0; tag = "R6";
      end
      default: ;
    endcase
    if (op == K_MOV) begin
      if (f1 != 0) m_reg[f1] = int'(insn[3:0]) % M;
      tag = (f1 == 0) ? "R9" : "R7";
      m_pc = (m_pc + 1) % N;
    end else if (op == K_JRZ) begin
      m_pc = (m_reg[f1] == 0) ? int'(insn[PCW-1:0]) : (m_pc + 1) % N;
      tag = "R8";
    end else if (op <= K_ROR) begin
      if (dst != 0) m_reg[dst] = res;
      if (dst == 0 || (op != K_MOV && op < K_SHL && f1 == 0)) tag = "R9";
      m_v = v; m_c = c; m_z = (res == 0); m_s = (res >> (W - 1)) & 1;
      m_pc = (m_pc + 1) % N;
    end else begin
      tag = "R10";
      m_pc = (m_pc + 1) % N;
    end
  endtask

  task automatic check(string t);
    logic [W+3:0] got, exp;
    got = {r7_out, flag_v, flag_z, flag_c, flag_s};
    exp = {W'(m_reg[7]), 1'(m_v), 1'(m_z), 1'(m_c), 1'(m_s)};
    n_checks++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s (R1 R12) next_pc=%0d r7/vzcs actual=%0d/%b expected=%0d/%b",
               t, m_pc, got[W+3:4], got[3:0], exp[W+3:4], exp[3:0]);
    end
  endtask

  initial begin
    rst = 1'b1;
    model_reset();
    repeat (3) @(negedge clk);
    check("R11");
    rst = 1'b0;
    // 17 passes of the program: the counter register covers all 16 values.
    for (int k = 0; k < 17 * N + 5; k++) begin
      @(negedge clk);
      step();
      check(tag);
    end
    // Reset in the middle of a run (R11).
    rst = 1'b1;
    repeat (2) @(negedge clk);
    model_reset();
    check("R11");
    rst = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      step();
      check(tag);
    end
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end
endmodule